// File: doc/BRIEF.md
# Host Control-Endpoint OUT Sequencer

This block is the host-side engine for the OUT data stage of a control transfer aimed at endpoint 0 of the addressed device. Software fills a small transmit FIFO and sets a go bit in an 8-bit control/status register. The engine then asks an abstract link layer for an OUT token addressed to endpoint 0. It streams the FIFO bytes as the data packet and waits for the handshake result, which is ACK, NAK, STALL or silence. It retries where the rules demand it and ends the attempt by recording the outcome in status bits and pulsing an endpoint interrupt.

Three failure kinds are kept apart: a STALL from the device, three consecutive silent tries, and NAKs that outlast a limit counted in frame ticks. After a NAK timeout the engine holds in a halted state. Clearing the timeout bit resumes retrying the same packet. Flushing the FIFO before clearing it abandons the packet instead.

Status register layout (read value `csr_rd_data`, written through `csr_wr_en`/`csr_wr_data`): bit 0 interrupt pending, bit 1 go (packet ready), bit 2 stall received, bit 3 flush command (write-only, reads 0), bit 4 no-response error, bit 5 FIFO holds data (read-only), bit 6 reads 0, bit 7 NAK timeout. Handshake codes on `hs_code`: 0 ACK, 1 NAK, 2 STALL, 3 no response.

FSM states are IDLE, TOKEN, DATA, WAIT_HS and HALT. The transitions are:
- IDLE→TOKEN when go is set.
- TOKEN→DATA on `tok_done`.
- DATA→WAIT_HS when the last beat is accepted.
- WAIT_HS→IDLE on ACK, on STALL, or on a third silent try.
- WAIT_HS→TOKEN on a NAK inside the limit or on a first or second silent try.
- WAIT_HS→HALT on a NAK once the limit is reached.
- HALT→TOKEN when bit 7 is cleared and the FIFO holds data.
- HALT→IDLE when bit 7 is cleared and the FIFO is empty.

Top module: `ctl_out_seq`

## Requirements
- R1: Writing 1 to bit 1 starts an attempt: `tok_req` rises with `tok_ep`=0, and after `tok_done` the FIFO bytes leave on `tx_data` in write order, with `tx_last` on the final byte; an empty FIFO sends one beat with `tx_zero`=1 and `tx_last`=1.
- R2: A STALL (code 2) sets bit 2, clears bit 1, raises the interrupt and starts no further try.
- R3: Three consecutive tries answered by no response (code 3) set bit 4, clear bit 1 and raise the interrupt; the silent count restarts at zero after any NAK and at every new attempt.
- R4: A NAK (code 1) causes another try of the same bytes; when a NAK arrives with at least `nak_limit` frame ticks counted since the attempt (or resume) began and `nak_limit` is nonzero, bit 7 is set, the interrupt is raised, bit 1 stays set and the engine halts with no link activity; `nak_limit`=0 never times out.
- R5: Clearing bit 7 while halted with data in the FIFO resumes tries of the same packet with the frame count restarted.
- R6: Flushing while halted and then clearing bit 7 aborts: bit 1 clears, no try is made and no interrupt is raised.
- R7: An ACK (code 0) ends the attempt with bits 2, 4 and 7 not set, bit 1 cleared and the FIFO emptied (bit 5 reads 0).
- R8: Every ending except an abort gives a one-cycle pulse on `ep_irq` in the cycle after the handshake, and sets bit 0 at the same time; writing 0 to bit 0 clears it.
- R9: Bits 0, 2, 4 and 7 change only by hardware setting them or by a write of 0 to that bit; a write of 1 leaves them unchanged.
- R10: Writing 1 to bit 3 empties the FIFO in one cycle (bit 5 reads 0 next cycle), except while in TOKEN or DATA, where the flush is ignored.
- R11: After a NAK, a STALL or a silent try the packet stays in the FIFO (bit 5 reads 1) and any retry resends identical bytes.
- R12: After reset the register reads 0 and `tok_req`, `tx_valid` and `ep_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_wr_en | input | 1 | Push one byte into the transmit FIFO |
| fifo_wr_data | input | DATA_W | Byte pushed |
| csr_wr_en | input | 1 | Write strobe for the control/status register |
| csr_wr_data | input | 8 | Value written |
| csr_rd_data | output | 8 | Current register value |
| nak_limit | input | LIMIT_W | NAK timeout in frame ticks, 0 disables |
| frame_tick | input | 1 | One-cycle frame strobe |
| tok_req | output | 1 | Request an OUT token |
| tok_ep | output | 4 | Endpoint number for the token (always 0) |
| tok_done | input | 1 | Link layer has sent the token |
| tx_valid | output | 1 | Data beat valid |
| tx_data | output | DATA_W | Data byte |
| tx_last | output | 1 | Final beat of the packet |
| tx_zero | output | 1 | Beat marks an empty packet |
| tx_ready | input | 1 | Link layer takes the beat |
| hs_valid | input | 1 | Handshake result strobe |
| hs_code | input | 2 | 0 ACK, 1 NAK, 2 STALL, 3 no response |
| ep_irq | output | 1 | Endpoint interrupt pulse |

## Verification
The bench builds the block with a 4-byte FIFO and a 3-bit NAK limit. With those values every packet length from empty to full can be swept, and every nonzero limit value 1 to 3 can be driven into a real timeout in a few hundred cycles. Scripted handshake sequences cover the silent-count restart after a NAK, the resume and abort paths, and a flush issued during the token. The frame tick count at each timeout is checked against the limit arithmetically.

// File: rtl/ctl_out_pkg.sv
package ctl_out_pkg;

    typedef enum logic [1:0] {
        HS_ACK   = 2'd0,
        HS_NAK   = 2'd1,
        HS_STALL = 2'd2,
        HS_NONE  = 2'd3
    } hs_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TOKEN,
        ST_DATA,
        ST_WAIT_HS,
        ST_HALT
    } seq_state_e;

    // Register bit positions
    localparam int BIT_PEND  = 0;
    localparam int BIT_GO    = 1;
    localparam int BIT_STALL = 2;
    localparam int BIT_FLUSH = 3;
    localparam int BIT_ERR   = 4;
    localparam int BIT_LVL   = 5;
    localparam int BIT_NAKTO = 7;

    localparam logic [7:0] STICKY_MASK = 8'b1001_0101;

endpackage

// File: rtl/ctl_out_fifo.sv
// Transmit FIFO with a packet base pointer: commit keeps the sent bytes
// consumed, rewind returns the read pointer to the packet start.
module ctl_out_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 8            // power of two, at least 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [DW-1:0]            wr_data,
    input  logic                     pop,
    input  logic                     commit,
    input  logic                     rewind,
    input  logic                     flush,
    output logic [DW-1:0]            head,
    output logic [$clog2(DEPTH):0]   avail,
    output logic [$clog2(DEPTH):0]   level
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

    logic [AW:0]   wr_q, rd_q, base_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic          push;

    assign level = wr_q - base_q;
    assign avail = wr_q - rd_q;
    assign head  = mem_q[rd_q[AW-1:0]];
    assign push  = wr_en && (level != FULL_LVL) && !flush;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q   <= '0;
            rd_q   <= '0;
            base_q <= '0;
        end else if (flush) begin
            wr_q   <= '0;
            rd_q   <= '0;
            base_q <= '0;
        end else begin
            if (push)        wr_q   <= wr_q + 1'b1;
            if (rewind)      rd_q   <= base_q;
            else if (pop)    rd_q   <= rd_q + 1'b1;
            if (commit)      base_q <= rd_q;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[wr_q[AW-1:0]] <= wr_data;
    end

    p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0) && (avail == '0));

    p_rewind_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rewind && !flush && !wr_en) |=> (avail == $past(level)) && $stable(level));

endmodule

// File: rtl/ctl_out_fsm.sv
// Attempt sequencer: token, data stream, handshake evaluation, retry and halt.
module ctl_out_fsm
    import ctl_out_pkg::*;
#(
    parameter int AW = 3,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pkt_rdy,
    input  logic          nak_to,
    input  logic [LW-1:0] nak_limit,
    input  logic          frame_tick,
    input  logic          tok_done,
    input  logic          tx_ready,
    input  logic          hs_valid,
    input  logic [1:0]    hs_code,
    input  logic [AW:0]   avail,
    input  logic          level_nz,
    output logic          tok_req,
    output logic          tx_valid,
    output logic          tx_last,
    output logic          tx_zero,
    output logic          pop,
    output logic          commit,
    output logic          rewind,
    output logic          busy_tx,
    output logic          ev_ack,
    output logic          ev_stall,
    output logic          ev_err,
    output logic          ev_nakto,
    output logic          ev_abort
);
    localparam logic [AW:0] ONE_BEAT = (AW+1)'(1);

    seq_state_e    state_q, state_d;
    logic [LW-1:0] frames_q;
    logic [1:0]    silent_q;
    logic          restart, nak_expired, hs_now;

    assign hs_now      = (state_q == ST_WAIT_HS) && hs_valid;
    assign nak_expired = (nak_limit != '0) && (frames_q >= nak_limit);
    assign restart     = ((state_q == ST_IDLE) && pkt_rdy) ||
                         ((state_q == ST_HALT) && !nak_to && level_nz);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (pkt_rdy) state_d = ST_TOKEN;
            ST_TOKEN:   if (tok_done) state_d = ST_DATA;
            ST_DATA:    if (tx_ready && tx_last) state_d = ST_WAIT_HS;
            ST_WAIT_HS: if (hs_valid) begin
                unique case (hs_code)
                    HS_ACK,
                    HS_STALL: state_d = ST_IDLE;
                    HS_NAK:   state_d = nak_expired ? ST_HALT : ST_TOKEN;
                    HS_NONE:  state_d = (silent_q == 2'd2) ? ST_IDLE : ST_TOKEN;
                    default:  state_d = ST_IDLE;
                endcase
            end
            ST_HALT:    if (!nak_to) state_d = level_nz ? ST_TOKEN : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs and events
    always_comb begin
        tok_req  = 1'b0;
        tx_valid = 1'b0;
        tx_last  = 1'b0;
        tx_zero  = 1'b0;
        pop      = 1'b0;
        commit   = 1'b0;
        rewind   = 1'b0;
        ev_ack   = 1'b0;
        ev_stall = 1'b0;
        ev_err   = 1'b0;
        ev_nakto = 1'b0;
        ev_abort = 1'b0;
        busy_tx  = (state_q == ST_TOKEN) || (state_q == ST_DATA);
        unique case (state_q)
            ST_IDLE:    ;
            ST_TOKEN:   tok_req = 1'b1;
            ST_DATA: begin
                tx_valid = 1'b1;
                tx_last  = (avail <= ONE_BEAT);
                tx_zero  = (avail == '0);
                pop      = tx_ready && (avail != '0);
            end
            ST_WAIT_HS: if (hs_valid) begin
                unique case (hs_code)
                    HS_ACK:   begin commit = 1'b1; ev_ack = 1'b1; end
                    HS_STALL: begin rewind = 1'b1; ev_stall = 1'b1; end
                    HS_NAK:   begin rewind = 1'b1; ev_nakto = nak_expired; end
                    HS_NONE:  begin rewind = 1'b1; ev_err = (silent_q == 2'd2); end
                    default:  ;
                endcase
            end
            ST_HALT:    ev_abort = !nak_to && !level_nz;
            default:    ;
        endcase
    end

    // Frame and silent-try counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frames_q <= '0;
            silent_q <= '0;
        end else if (restart) begin
            frames_q <= '0;
            silent_q <= '0;
        end else begin
            if (frame_tick && (state_q != ST_IDLE) && (frames_q != '1))
                frames_q <= frames_q + 1'b1;
            if (hs_now && (hs_code == HS_NAK))
                silent_q <= '0;
            else if (hs_now && (hs_code == HS_NONE))
                silent_q <= (silent_q == 2'd2) ? 2'd0 : silent_q + 2'd1;
        end
    end

    p_stall_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_now && (hs_code == HS_STALL)) |=> (state_q == ST_IDLE) && !tok_req);

    p_silent_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        silent_q != 2'd3);

    p_halt_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_nakto |=> (state_q == ST_HALT) && !tok_req && !tx_valid);

    p_abort_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_abort |=> (state_q == ST_IDLE));

endmodule

// File: rtl/ctl_out_csr.sv
// Control/status register: go bit, sticky outcome bits, flush command, interrupt.
module ctl_out_csr
    import ctl_out_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       ev_ack,
    input  logic       ev_stall,
    input  logic       ev_err,
    input  logic       ev_nakto,
    input  logic       ev_abort,
    input  logic       level_nz,
    input  logic       flush_block,
    output logic       pkt_rdy,
    output logic       nak_to,
    output logic       flush,
    output logic       ep_irq,
    output logic [7:0] rd_data
);
    logic [7:0] stk_q, stk_d, set_vec, clr_vec;
    logic       pkt_q, irq_q, ev_any, ev_end;

    assign ev_any = ev_ack || ev_stall || ev_err || ev_nakto;
    assign ev_end = ev_ack || ev_stall || ev_err || ev_abort;
    assign flush  = wr_en && wr_data[BIT_FLUSH] && !flush_block;

    always_comb begin
        set_vec            = '0;
        set_vec[BIT_PEND]  = ev_any;
        set_vec[BIT_STALL] = ev_stall;
        set_vec[BIT_ERR]   = ev_err;
        set_vec[BIT_NAKTO] = ev_nakto;
        clr_vec            = wr_en ? ~wr_data : '0;
        stk_d              = ((stk_q & ~clr_vec) | set_vec) & STICKY_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stk_q <= '0;
            pkt_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            stk_q <= stk_d;
            irq_q <= ev_any;
            if (ev_end)                          pkt_q <= 1'b0;
            else if (wr_en && wr_data[BIT_GO])   pkt_q <= 1'b1;
        end
    end

    always_comb begin
        rd_data          = stk_q;
        rd_data[BIT_GO]  = pkt_q;
        rd_data[BIT_LVL] = level_nz;
    end

    assign pkt_rdy = pkt_q;
    assign nak_to  = stk_q[BIT_NAKTO];
    assign ep_irq  = irq_q;

    p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ep_irq |=> !ep_irq);

    p_err_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stk_q[BIT_ERR]) |-> ep_irq && stk_q[BIT_PEND]);

    p_nakto_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stk_q[BIT_NAKTO]) |-> ep_irq && pkt_q);

    p_ack_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ack |=> ep_irq && !pkt_q);

    p_abort_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_abort |=> !ep_irq && !pkt_q);

endmodule

// File: rtl/ctl_out_seq.sv
module ctl_out_seq
    import ctl_out_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 64,
    parameter int LIMIT_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fifo_wr_en,
    input  logic [DATA_W-1:0]  fifo_wr_data,
    input  logic               csr_wr_en,
    input  logic [7:0]         csr_wr_data,
    output logic [7:0]         csr_rd_data,
    input  logic [LIMIT_W-1:0] nak_limit,
    input  logic               frame_tick,
    output logic               tok_req,
    output logic [3:0]         tok_ep,
    input  logic               tok_done,
    output logic               tx_valid,
    output logic [DATA_W-1:0]  tx_data,
    output logic               tx_last,
    output logic               tx_zero,
    input  logic               tx_ready,
    input  logic               hs_valid,
    input  logic [1:0]         hs_code,
    output logic               ep_irq
);
    localparam int AW = $clog2(FIFO_DEPTH);

    logic [AW:0] avail, level;
    logic        level_nz, pop, commit, rewind, flush, busy_tx;
    logic        pkt_rdy, nak_to;
    logic        ev_ack, ev_stall, ev_err, ev_nakto, ev_abort;

    assign level_nz = (level != '0);
    assign tok_ep   = 4'd0;

    ctl_out_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fifo_wr_en),
        .wr_data (fifo_wr_data),
        .pop     (pop),
        .commit  (commit),
        .rewind  (rewind),
        .flush   (flush),
        .head    (tx_data),
        .avail   (avail),
        .level   (level)
    );

    ctl_out_fsm #(.AW(AW), .LW(LIMIT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pkt_rdy    (pkt_rdy),
        .nak_to     (nak_to),
        .nak_limit  (nak_limit),
        .frame_tick (frame_tick),
        .tok_done   (tok_done),
        .tx_ready   (tx_ready),
        .hs_valid   (hs_valid),
        .hs_code    (hs_code),
        .avail      (avail),
        .level_nz   (level_nz),
        .tok_req    (tok_req),
        .tx_valid   (tx_valid),
        .tx_last    (tx_last),
        .tx_zero    (tx_zero),
        .pop        (pop),
        .commit     (commit),
        .rewind     (rewind),
        .busy_tx    (busy_tx),
        .ev_ack     (ev_ack),
        .ev_stall   (ev_stall),
        .ev_err     (ev_err),
        .ev_nakto   (ev_nakto),
        .ev_abort   (ev_abort)
    );

    ctl_out_csr u_csr (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (csr_wr_en),
        .wr_data     (csr_wr_data),
        .ev_ack      (ev_ack),
        .ev_stall    (ev_stall),
        .ev_err      (ev_err),
        .ev_nakto    (ev_nakto),
        .ev_abort    (ev_abort),
        .level_nz    (level_nz),
        .flush_block (busy_tx),
        .pkt_rdy     (pkt_rdy),
        .nak_to      (nak_to),
        .flush       (flush),
        .ep_irq      (ep_irq),
        .rd_data     (csr_rd_data)
    );

    p_token_ep0_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tok_req) |-> (tok_ep == 4'd0) && !tx_valid);

endmodule

// File: tb/ctl_out_seq_tb.sv
module ctl_out_seq_tb_top;
    localparam int DW    = 8;
    localparam int DEPTH = 4;
    localparam int LW    = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fifo_wr_en = 1'b0;
    logic [DW-1:0] fifo_wr_data = '0;
    logic          csr_wr_en = 1'b0;
    logic [7:0]    csr_wr_data = '0;
    logic [7:0]    csr_rd_data;
    logic [LW-1:0] nak_limit = '0;
    logic          frame_tick = 1'b0;
    logic          tok_req;
    logic [3:0]    tok_ep;
    logic          tok_done = 1'b0;
    logic          tx_valid;
    logic [DW-1:0] tx_data;
    logic          tx_last;
    logic          tx_zero;
    logic          tx_ready = 1'b1;
    logic          hs_valid = 1'b0;
    logic [1:0]    hs_code = 2'd0;
    logic          ep_irq;

    always #4 clk = ~clk;   // 125 MHz

    ctl_out_seq #(.DATA_W(DW), .FIFO_DEPTH(DEPTH), .LIMIT_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data),
        .csr_wr_en(csr_wr_en), .csr_wr_data(csr_wr_data), .csr_rd_data(csr_rd_data),
        .nak_limit(nak_limit), .frame_tick(frame_tick), .tok_req(tok_req), .tok_ep(tok_ep),
        .tok_done(tok_done), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_zero(tx_zero), .tx_ready(tx_ready), .hs_valid(hs_valid), .hs_code(hs_code),
        .ep_irq(ep_irq)
    );

    int checks = 0, errors = 0;
    logic [1:0] script [8];
    logic [7:0] exp_data [DEPTH];
    int tries = 0, irqs = 0, nticks = 0, tcnt = 0, ft_period = 30;
    int beat_idx = 0, payload_bad = 0, sent_len = 0, hs_wait = 0;
    bit zero_seen = 0, bad_ep = 0, done_all = 0;

    // Link layer model and observers, all at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            hs_valid = 1'b0;
            if (hs_wait > 0) begin
                hs_wait--;
                if (hs_wait == 0) begin
                    hs_valid = 1'b1;
                    hs_code  = script[(tries > 7) ? 7 : tries];
                    tries++;
                end
            end
            if (tok_req && !tok_done) begin
                tok_done = 1'b1;
                beat_idx = 0;
                if (tok_ep != 4'd0) bad_ep = 1;
            end else begin
                tok_done = 1'b0;
            end
            if (tx_valid) begin
                if (tx_zero) zero_seen = 1;
                else begin
                    if (beat_idx >= DEPTH || tx_data !== exp_data[beat_idx]) payload_bad++;
                    beat_idx++;
                end
                if (tx_last) begin
                    sent_len = beat_idx;
                    hs_wait  = 2;
                end
            end
            if (ep_irq) irqs++;
            tcnt++;
            frame_tick = (tcnt % ft_period == 0);
            if (frame_tick) nticks++;
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_rng(string tag, int act, int lo, int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic csr_write(logic [7:0] v);
        step();
        csr_wr_en = 1'b1;
        csr_wr_data = v;
        step();
        csr_wr_en = 1'b0;
    endtask

    task automatic load(int len, int seed);
        csr_write(8'h08);   // flush
        for (int i = 0; i < len; i++) begin
            step();
            fifo_wr_en   = 1'b1;
            fifo_wr_data = 8'((seed * 37 + i * 11) & 8'hFF);
            exp_data[i]  = fifo_wr_data;
        end
        step();
        fifo_wr_en = 1'b0;
    endtask

    task automatic set_script(logic [1:0] a, logic [1:0] b, logic [1:0] c, logic [1:0] d,
                              logic [1:0] e, logic [1:0] f, logic [1:0] g, logic [1:0] h);
        script[0] = a; script[1] = b; script[2] = c; script[3] = d;
        script[4] = e; script[5] = f; script[6] = g; script[7] = h;
    endtask

    task automatic clear_obs();
        tries = 0; irqs = 0; nticks = 0; tcnt = 0;
        zero_seen = 0; sent_len = -1; payload_bad = 0;
    endtask

    task automatic go();
        clear_obs();
        csr_write(8'h02);
    endtask

    task automatic wait_irq(int maxc);
        int n0 = irqs;
        for (int i = 0; i < maxc && irqs == n0; i++) step();
    endtask

    initial begin
        set_script(0, 0, 0, 0, 0, 0, 0, 0);
        repeat (5) step();
        rst_n = 1'b1;
        step();
        // R12: reset state
        chk("R12 csr after reset", csr_rd_data, 0);
        chk("R12 idle link outputs", {tok_req, tx_valid, ep_irq}, 0);

        // R1 R7 R8: ACK for every length 0..DEPTH
        for (int len = 0; len <= DEPTH; len++) begin
            load(len, len + 1);
            set_script(0, 0, 0, 0, 0, 0, 0, 0);
            go();
            wait_irq(200);
            chk("R8 single irq on ACK", irqs, 1);
            chk("R1 tries on ACK", tries, 1);
            chk("R1 bytes sent", sent_len, len);
            chk("R1 payload order", payload_bad, 0);
            chk("R1 zero-length marker", zero_seen, (len == 0) ? 1 : 0);
            chk("R7 status after ACK", csr_rd_data, 8'h01);
            step();
            chk("R8 irq is one cycle", irqs, 1);
        end
        chk("R1 token endpoint 0", bad_ep, 0);

        // R9 sticky pending bit, then cleared by 0
        csr_write(8'h01);
        chk("R9 write 1 keeps pending", csr_rd_data, 8'h01);
        csr_write(8'h00);
        chk("R8 write 0 clears pending", csr_rd_data, 8'h00);

        // R2 R11: STALL
        load(3, 7);
        set_script(2, 2, 2, 2, 2, 2, 2, 2);
        go();
        wait_irq(200);
        chk("R2 status after STALL", csr_rd_data, 8'h25);
        repeat (50) step();
        chk("R2 no retry after STALL", tries, 1);
        csr_write(8'hF5);
        chk("R9 write 1 keeps stall bits", csr_rd_data, 8'h25);
        csr_write(8'h20);
        chk("R9 write 0 clears stall bits", csr_rd_data, 8'h20);
        csr_write(8'h08);
        chk("R10 flush in idle empties", csr_rd_data, 8'h00);

        // R3 R11: three silent tries
        load(2, 3);
        set_script(3, 3, 3, 3, 3, 3, 3, 3);
        go();
        wait_irq(300);
        chk("R3 tries before error", tries, 3);
        chk("R3 status after error", csr_rd_data, 8'h31);
        chk("R11 retries identical", payload_bad, 0);
        repeat (40) step();
        chk("R3 no try after error", tries, 3);

        // R3: two silent then ACK, new attempt restarts the count
        load(2, 4);
        set_script(3, 3, 0, 0, 0, 0, 0, 0);
        go();
        wait_irq(300);
        chk("R3 two silent then ACK tries", tries, 3);
        chk("R3 two silent then ACK status", csr_rd_data, 8'h01);

        // R3: NAK restarts the silent count
        load(1, 5);
        set_script(3, 3, 1, 3, 3, 3, 0, 0);
        nak_limit = '0;
        go();
        wait_irq(400);
        chk("R3 NAK restarts silent count", tries, 6);
        chk("R3 status after late error", csr_rd_data, 8'h31);
        chk("R11 payload across NAK", payload_bad, 0);

        // R4 R5 R6: NAK timeout for every nonzero limit
        ft_period = 30;
        for (int lim = 1; lim < (1 << LW) && lim <= 3; lim++) begin
            int t_hold;
            load(2, 10 + lim);
            set_script(1, 1, 1, 1, 1, 1, 1, 1);
            nak_limit = LW'(lim);
            go();
            wait_irq(2000);
            chk("R4 status at NAK timeout", csr_rd_data, 8'hA3);
            chk_rng("R4 frame ticks at timeout", nticks, lim, lim + 1);
            chk("R11 NAK retries identical", payload_bad, 0);
            t_hold = tries;
            repeat (40) step();
            chk("R4 halted with no tries", tries, t_hold);
            if (lim == 3) begin
                set_script(0, 0, 0, 0, 0, 0, 0, 0);
                csr_write(8'h76);
                wait_irq(400);
                chk("R5 resume then ACK status", csr_rd_data, 8'h01);
                chk("R5 resumed one more try", tries, t_hold + 1);
            end else begin
                nticks = 0; tcnt = 0;
                csr_write(8'h76);
                wait_irq(2000);
                chk("R5 second timeout status", csr_rd_data, 8'hA3);
                chk_rng("R5 frame count restarted", nticks, lim, lim + 1);
                csr_write(8'h88);
                chk("R10 flush while halted", csr_rd_data, 8'h82);
                t_hold = tries;
                csr_write(8'h00);
                step();
                chk("R6 abort clears go", csr_rd_data, 8'h00);
                repeat (40) step();
                chk("R6 abort makes no try", tries, t_hold);
                chk("R6 abort raises no irq", irqs, 2);
            end
        end

        // R4: limit 0 never times out
        ft_period = 3;
        nak_limit = '0;
        load(3, 20);
        set_script(1, 1, 1, 1, 1, 1, 1, 0);
        go();
        wait_irq(600);
        chk("R4 limit 0 keeps retrying", tries, 8);
        chk("R4 limit 0 ends on ACK", csr_rd_data, 8'h01);
        ft_period = 30;

        // R10: flush during token is ignored
        load(3, 30);
        set_script(2, 2, 2, 2, 2, 2, 2, 2);
        go();
        for (int i = 0; i < 20 && !tok_req; i++) step();
        csr_wr_en = 1'b1;
        csr_wr_data = 8'h08;
        step();
        csr_wr_en = 1'b0;
        wait_irq(200);
        chk("R10 flush ignored in token: bytes", sent_len, 3);
        chk("R10 flush ignored in token: status", csr_rd_data, 8'h25);

        done_all = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_all) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule